// File: doc/BRIEF.md
# DDR Burst Latency and Byte-Mask Scheduler

This block sits behind a memory command decoder and turns accepted read and write commands into bus timing. It takes the programmed CAS latency, the posted-command additive latency and the burst length. It then works out the clock in which each burst begins, counts the beats of the burst at two beats per clock, and produces the column address of every beat. Burst addresses wrap inside the aligned column block.

Write bursts are sampled one clock earlier than read bursts. Each byte lane of each beat carries its own mask bit, and masked bytes are left unchanged in a small internal column store. Read bursts drive the stored words back out. A command that arrives while earlier bursts are still pending waits in a latency line. Its burst starts on the exact clock its countdown ends, so bursts issued one burst length apart run with no idle clock between them. The controller keeps commands at least one burst apart and leaves one extra clock when a write follows a read. The configuration is held steady while any command is pending.

Top module: `ddr_lat_sched`

## Requirements
- R1: While reset is asserted and after it is released with no command, data_valid_o, rd_en_o, byte_we_o and rd_data_o are all zero.
- R2: Read latency is AL plus CL. cfg_cl6_i = 0 selects CL 5 and 1 selects CL 6. cfg_al_i values 0 to 4 give that AL, and values 5 to 7 act as 4. A read accepted in clock c drives its first beats in clock c + AL + CL.
- R3: A write accepted in clock c samples its first beats in clock c + AL + CL - 1.
- R4: cfg_bl8_i = 0 gives 4 beats (2 clocks) and 1 gives 8 beats (4 clocks). In each clock, beat 2p uses bus bits [15:0] and beat 2p+1 uses bits [31:16] of wr_data_i and rd_data_o.
- R5: Beat i of a burst starting at column s uses column (s with its low log2(BL) bits replaced by (s + i) mod BL).
- R6: During a write clock, byte_we_o[2j+b] = NOT wr_mask_i[2j+b] for beat j (0 = lower half of the bus) and byte b (0 = data bits 7:0, 1 = bits 15:8). Outside write clocks byte_we_o is zero.
- R7: A masked byte keeps its earlier content, and an unmasked byte takes the beat's data. A later read returns this merged word.
- R8: rd_en_o is high exactly in the clocks of a read burst. rd_data_o is zero in every other clock.
- R9: Two commands of the same kind accepted BL/2 clocks apart produce bursts with no gap between them.
- R10: data_valid_o is high exactly in the clocks of a read or write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command accepted this clock |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_col_i | input | COL_W | Starting column of the burst |
| cfg_cl6_i | input | 1 | CAS latency select (0: 5, 1: 6) |
| cfg_al_i | input | 3 | Additive latency, 0 to 4 |
| cfg_bl8_i | input | 1 | Burst length select (0: 4, 1: 8) |
| wr_data_i | input | 2*DQ_W | Two write beats of this clock |
| wr_mask_i | input | 2*DQ_W/8 | Byte masks of the two beats, 1 = keep old byte |
| data_valid_o | output | 1 | Bus carries burst data this clock |
| rd_en_o | output | 1 | Read data driven this clock |
| byte_we_o | output | 2*DQ_W/8 | Per-beat, per-byte write enable |
| rd_data_o | output | 2*DQ_W | Two read beats of this clock |

## Verification
The bound checker checks the relations between output ports on every clock. byte_we_o stays zero outside write windows and follows the inverted mask inside them, rd_en_o stays inside the data window, rd_data_o is zero when nothing is read, and every burst lasts at least two clocks. Only the bench scenarios can show the latency values for each CL and AL setting, including the clamp on large AL, the wrap order of addresses, gapless back-to-back bursts, and the merge of masked writes with older contents. To do this, the bench compares every clock against a scheduled reference and a mask-aware copy of the store.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
  localparam int unsigned CL_BASE = 5;
  localparam int unsigned AL_MAX  = 4;
  localparam int unsigned AL_W    = 3;
  localparam int unsigned BL_MAX  = 8;

  typedef struct packed {
    logic            cl6;
    logic [AL_W-1:0] al;
    logic            bl8;
  } lat_cfg_t;
endpackage

// File: rtl/ddr_lat_calc.sv
module ddr_lat_calc
  import ddr_sched_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  lat_cfg_t         cfg_i,
  input  logic             write_i,
  output logic [IDX_W-1:0] slot_idx_o
);
  logic [AL_W-1:0]  al_eff;
  logic [IDX_W-1:0] rl;

  always_comb begin
    al_eff = (cfg_i.al > AL_W'(AL_MAX)) ? AL_W'(AL_MAX) : cfg_i.al;
    rl = IDX_W'(al_eff) + IDX_W'(CL_BASE) + IDX_W'(cfg_i.cl6);
    // slot 0 fires in the first data clock; write lands one clock earlier
    slot_idx_o = write_i ? rl - IDX_W'(2) : rl - IDX_W'(1);
  end
endmodule

// File: rtl/ddr_slot_line.sv
module ddr_slot_line #(
  parameter int unsigned SLOTS = 10,
  parameter int unsigned COL_W = 6,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             push_wr_i,
  input  logic [COL_W-1:0] push_col_i,
  input  logic [IDX_W-1:0] push_idx_i,
  output logic             head_vld_o,
  output logic             head_wr_o,
  output logic [COL_W-1:0] head_col_o
);
  logic             vld_q [SLOTS];
  logic             wr_q  [SLOTS];
  logic [COL_W-1:0] col_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SLOTS; k++) begin
        vld_q[k] <= 1'b0;
        wr_q[k]  <= 1'b0;
        col_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (push_i && push_idx_i == IDX_W'(k)) begin
          vld_q[k] <= 1'b1;
          wr_q[k]  <= push_wr_i;
          col_q[k] <= push_col_i;
        end else if (k == SLOTS - 1) begin
          vld_q[k] <= 1'b0;
          wr_q[k]  <= 1'b0;
          col_q[k] <= '0;
        end else begin
          vld_q[k] <= vld_q[k+1];
          wr_q[k]  <= wr_q[k+1];
          col_q[k] <= col_q[k+1];
        end
      end
    end
  end

  assign head_vld_o = vld_q[0];
  assign head_wr_o  = wr_q[0];
  assign head_col_o = col_q[0];
endmodule

// File: rtl/ddr_burst_ctl.sv
module ddr_burst_ctl
  import ddr_sched_pkg::*;
#(
  parameter int unsigned COL_W = 6,
  parameter int unsigned BEATS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bl8_i,
  input  logic                        head_vld_i,
  input  logic                        head_wr_i,
  input  logic [COL_W-1:0]            head_col_i,
  output logic                        busy_o,
  output logic                        rd_o,
  output logic                        wr_o,
  output logic [BEATS-1:0][COL_W-1:0] beat_col_o
);
  localparam int unsigned PAIR_W = $clog2(BL_MAX / BEATS);

  logic              act_q, wr_q;
  logic [COL_W-1:0]  col_q;
  logic [PAIR_W-1:0] pair_q;

  logic              cur_wr;
  logic [COL_W-1:0]  cur_col;
  logic [PAIR_W-1:0] cur_pair, last_pair;

  always_comb begin
    // a new start takes the bus over from any burst still running
    cur_wr    = head_vld_i ? head_wr_i  : wr_q;
    cur_col   = head_vld_i ? head_col_i : col_q;
    cur_pair  = head_vld_i ? '0         : pair_q;
    busy_o    = head_vld_i | act_q;
    last_pair = bl8_i ? PAIR_W'(3) : PAIR_W'(1);
  end

  assign rd_o = busy_o & ~cur_wr;
  assign wr_o = busy_o &  cur_wr;

  for (genvar j = 0; j < BEATS; j++) begin : g_beat
    logic [2:0] off;
    assign off = cur_col[2:0] + {cur_pair, 1'b0} + 3'(j);
    assign beat_col_o[j] = bl8_i ? {cur_col[COL_W-1:3], off[2:0]}
                                 : {cur_col[COL_W-1:2], off[1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      col_q  <= '0;
      pair_q <= '0;
    end else if (busy_o && cur_pair != last_pair) begin
      act_q  <= 1'b1;
      wr_q   <= cur_wr;
      col_q  <= cur_col;
      pair_q <= cur_pair + PAIR_W'(1);
    end else begin
      act_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ddr_col_store.sv
module ddr_col_store #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DQ_W  = 16,
  parameter int unsigned BEATS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [BEATS-1:0][COL_W-1:0] beat_col_i,
  input  logic [BEATS*DQ_W/8-1:0]     byte_we_i,
  input  logic [BEATS*DQ_W-1:0]       wdata_i,
  input  logic                        rd_i,
  output logic [BEATS*DQ_W-1:0]       rdata_o
);
  localparam int unsigned DEPTH = 2 ** COL_W;
  localparam int unsigned BYTES = DQ_W / 8;

  logic [DQ_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else begin
      for (int j = 0; j < BEATS; j++)
        for (int b = 0; b < BYTES; b++)
          if (byte_we_i[j*BYTES+b])
            mem_q[beat_col_i[j]][b*8 +: 8] <= wdata_i[j*DQ_W + b*8 +: 8];
    end
  end

  for (genvar j = 0; j < BEATS; j++) begin : g_rd
    assign rdata_o[j*DQ_W +: DQ_W] = rd_i ? mem_q[beat_col_i[j]] : '0;
  end
endmodule

// File: rtl/ddr_lat_sched.sv
module ddr_lat_sched
  import ddr_sched_pkg::*;
#(
  parameter int unsigned COL_W = 6,
  parameter int unsigned DQ_W  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic                  cmd_write_i,
  input  logic [COL_W-1:0]      cmd_col_i,
  input  logic                  cfg_cl6_i,
  input  logic [2:0]            cfg_al_i,
  input  logic                  cfg_bl8_i,
  input  logic [2*DQ_W-1:0]     wr_data_i,
  input  logic [2*DQ_W/8-1:0]   wr_mask_i,
  output logic                  data_valid_o,
  output logic                  rd_en_o,
  output logic [2*DQ_W/8-1:0]   byte_we_o,
  output logic [2*DQ_W-1:0]     rd_data_o
);
  localparam int unsigned BEATS = 2;
  localparam int unsigned BYTES = DQ_W / 8;
  localparam int unsigned SLOTS = AL_MAX + CL_BASE + 1;
  localparam int unsigned IDX_W = $clog2(SLOTS + 1);

  lat_cfg_t                    cfg;
  logic [IDX_W-1:0]            slot_idx;
  logic                        head_vld, head_wr;
  logic [COL_W-1:0]            head_col;
  logic                        wr_win;
  logic [BEATS-1:0][COL_W-1:0] beat_col;

  assign cfg = '{cl6: cfg_cl6_i, al: cfg_al_i, bl8: cfg_bl8_i};

  ddr_lat_calc #(.IDX_W(IDX_W)) u_calc (
    .cfg_i      (cfg),
    .write_i    (cmd_write_i),
    .slot_idx_o (slot_idx)
  );

  ddr_slot_line #(.SLOTS(SLOTS), .COL_W(COL_W), .IDX_W(IDX_W)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (cmd_valid_i),
    .push_wr_i  (cmd_write_i),
    .push_col_i (cmd_col_i),
    .push_idx_i (slot_idx),
    .head_vld_o (head_vld),
    .head_wr_o  (head_wr),
    .head_col_o (head_col)
  );

  ddr_burst_ctl #(.COL_W(COL_W), .BEATS(BEATS)) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bl8_i      (cfg_bl8_i),
    .head_vld_i (head_vld),
    .head_wr_i  (head_wr),
    .head_col_i (head_col),
    .busy_o     (data_valid_o),
    .rd_o       (rd_en_o),
    .wr_o       (wr_win),
    .beat_col_o (beat_col)
  );

  assign byte_we_o = {(BEATS*BYTES){wr_win}} & ~wr_mask_i;

  ddr_col_store #(.COL_W(COL_W), .DQ_W(DQ_W), .BEATS(BEATS)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_col_i (beat_col),
    .byte_we_i  (byte_we_o),
    .wdata_i    (wr_data_i),
    .rd_i       (rd_en_o),
    .rdata_o    (rd_data_o)
  );
endmodule

// File: rtl/ddr_lat_sched_chk.sv
module ddr_lat_sched_chk #(
  parameter int unsigned DQ_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*DQ_W/8-1:0] wr_mask_i,
  input logic                data_valid_o,
  input logic                rd_en_o,
  input logic [2*DQ_W/8-1:0] byte_we_o,
  input logic [2*DQ_W-1:0]   rd_data_o
);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> (!rd_en_o && byte_we_o == '0));

  p_rd_in_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> data_valid_o);

  p_rdata_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |-> rd_data_o == '0);

  p_no_we_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> byte_we_o == '0);

  p_mask_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_valid_o && !rd_en_o) |-> byte_we_o == ~wr_mask_i);

  p_min_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |=> data_valid_o);
endmodule

bind ddr_lat_sched ddr_lat_sched_chk #(.DQ_W(DQ_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_mask_i    (wr_mask_i),
  .data_valid_o (data_valid_o),
  .rd_en_o      (rd_en_o),
  .byte_we_o    (byte_we_o),
  .rd_data_o    (rd_data_o)
);

// File: tb/ddr_lat_sched_tb.sv
module ddr_lat_sched_tb;
  localparam int COL_W = 6;
  localparam int DQ_W  = 16;
  localparam int MAXC  = 4000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_valid_i = 1'b0, cmd_write_i = 1'b0;
  logic [COL_W-1:0]  cmd_col_i = '0;
  logic              cfg_cl6_i = 1'b0, cfg_bl8_i = 1'b0;
  logic [2:0]        cfg_al_i = '0;
  logic [2*DQ_W-1:0] wr_data_i = '0;
  logic [3:0]        wr_mask_i = '0;
  logic              data_valid_o, rd_en_o;
  logic [3:0]        byte_we_o;
  logic [2*DQ_W-1:0] rd_data_o;

  ddr_lat_sched #(.COL_W(COL_W), .DQ_W(DQ_W)) u_dut (.*);

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  int sch_kind [MAXC];
  int sch_col  [MAXC];
  int sch_pair [MAXC];
  int sch_bl   [MAXC];
  logic [15:0] ref_mem [64];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic int beat_col(input int base, input int i, input int bl);
    return base - (base % bl) + ((base % bl) + i) % bl;
  endfunction

  task automatic tick(input bit v, input bit w, input int col);
    int k, bl, c;
    logic [3:0] exp_we;
    logic [31:0] exp_rd;
    @(negedge clk_i);
    cmd_valid_i = v; cmd_write_i = w; cmd_col_i = COL_W'(col);
    wr_data_i = $urandom; wr_mask_i = 4'($urandom_range(0, 15));
    #1;
    k = sch_kind[cyc];
    chk("R10 data_valid", 32'(data_valid_o), 32'(k != 0));
    chk("R2 R8 rd_en", 32'(rd_en_o), 32'(k == 1));
    exp_we = (k == 2) ? ~wr_mask_i : 4'h0;
    chk("R3 R6 byte_we", 32'(byte_we_o), 32'(exp_we));
    exp_rd = '0;
    if (k == 1)
      for (int j = 0; j < 2; j++)
        exp_rd[j*16 +: 16] = ref_mem[beat_col(sch_col[cyc], 2*sch_pair[cyc]+j, sch_bl[cyc])];
    chk("R5 R7 rd_data", rd_data_o, exp_rd);
    if (k == 2)
      for (int j = 0; j < 2; j++)
        for (int b = 0; b < 2; b++)
          if (!wr_mask_i[j*2+b]) begin
            c = beat_col(sch_col[cyc], 2*sch_pair[cyc]+j, sch_bl[cyc]);
            ref_mem[c][b*8 +: 8] = wr_data_i[j*16 + b*8 +: 8];
          end
    if (v) begin
      int al, lat;
      al  = (cfg_al_i > 4) ? 4 : int'(cfg_al_i);
      lat = al + (cfg_cl6_i ? 6 : 5) - (w ? 1 : 0);
      bl  = cfg_bl8_i ? 8 : 4;
      for (int p = 0; p < bl / 2; p++) begin
        sch_kind[cyc+lat+p] = w ? 2 : 1;
        sch_col[cyc+lat+p]  = col;
        sch_pair[cyc+lat+p] = p;
        sch_bl[cyc+lat+p]   = bl;
      end
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0);
  endtask

  task automatic cmd(input bit w, input int col, input int gap);
    tick(1, w, col);
    idle(gap - 1);
  endtask

  task automatic set_cfg(input bit cl6, input int al, input bit bl8);
    idle(14);
    cfg_cl6_i = cl6; cfg_al_i = 3'(al); cfg_bl8_i = bl8;
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) begin
      sch_kind[i] = 0; sch_col[i] = 0; sch_pair[i] = 0; sch_bl[i] = 4;
    end
    for (int a = 0; a < 64; a++) ref_mem[a] = '0;
    #5;
    // R1: outputs quiet while reset is held
    chk("R1 reset data_valid", 32'(data_valid_o), 32'd0);
    chk("R1 reset rd_en", 32'(rd_en_o), 32'd0);
    chk("R1 reset byte_we", 32'(byte_we_o), 32'd0);
    chk("R1 reset rd_data", rd_data_o, 32'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    idle(4);

    // CL5 AL0 BL4; R9 back-to-back writes then reads, R5 wrap at col 5
    cmd(1, 0, 2); cmd(1, 4, 2); cmd(1, 9, 2);
    idle(3);
    cmd(0, 0, 2); cmd(0, 4, 2); cmd(0, 5, 2); cmd(0, 10, 3);
    cmd(1, 0, 2); cmd(1, 5, 3); cmd(0, 0, 2); cmd(0, 6, 3);

    // CL6 AL3 BL8; R4 eight-beat bursts, R9 contiguous, R5 wrap at col 13
    set_cfg(1, 3, 1);
    cmd(1, 8, 4); cmd(1, 16, 4); cmd(1, 13, 4);
    idle(2);
    cmd(0, 8, 4); cmd(0, 16, 4); cmd(0, 13, 4); cmd(0, 11, 5);

    // CL5, AL 7 acts as 4 (R2), BL8
    set_cfg(0, 7, 1);
    cmd(1, 32, 4); cmd(0, 32, 5); cmd(1, 37, 4); cmd(0, 37, 4); cmd(0, 34, 5);

    // CL6 AL2 BL4 mixed traffic, repeated masked writes (R7)
    set_cfg(1, 2, 0);
    begin
      bit prev_rd;
      prev_rd = 0;
      for (int i = 0; i < 60; i++) begin
        bit w;
        int col;
        w   = 1'($urandom_range(0, 1));
        col = $urandom_range(40, 47);
        if (w && prev_rd) idle(1);
        cmd(w, col, 2);
        prev_rd = !w;
      end
    end
    idle(3);
    for (int c = 40; c < 48; c += 4) cmd(0, c, 2);
    idle(16);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule